// File: doc/BRIEF.md
# Dual-Bank DRAM Address Multiplexer

This block sits between a Z80-style processor bus and two 64K x 8 dynamic RAM banks, each organised as 256 rows by 256 columns and fed through one shared 8-bit multiplexed address bus. On each memory request that targets RAM, it produces that bank's row address with a row strobe. It then switches the bus to the column address and finally asserts the column strobe. It also drives a write enable decoded from the read and write strobes.

A bank-select input chooses between a fast bank and a shared bank, and the two banks split the CPU address in opposite ways. For the fast bank, the low seven address bits form the row and bits 13 to 7 form the column. For the shared bank, bits 13 to 7 form the row and the low seven bits form the column. In every case a per-bank page bit becomes the most significant bit of the row or column, and the row and column each use a different page bit. Only the selected bank is strobed. Requests to the lowest 16K of the address space, which is not RAM, produce no strobes.

The request is captured on the first clock edge that sees the request active with a RAM address. The multiplexer switch and the column strobe each follow one clock after the event before them. All strobes are released on the clock after the request goes inactive.

Top module: `dram_addr_mux`

## Requirements
- R1: After reset, all four RAS/CAS strobes and `we_n` are high (inactive) and `ma` is 0.
- R2: A cycle starts when, at a clock edge, `mreq_n` is low and `cpu_addr[15:14]` is nonzero. If `bank_shared` is 0 at that edge, `fast_ras_n` goes low after that edge and `ma` becomes `{fast_pg_row, cpu_addr[6:0]}`.
- R3: For a fast-bank cycle, one clock after RAS falls `ma` becomes `{fast_pg_col, cpu_addr[13:7]}` while `fast_cas_n` stays high. One further clock later `fast_cas_n` goes low, and `ma` holds the column value while CAS is low.
- R4: If `bank_shared` is 1 at the start edge, the shared bank is used. The row phase drives `ma` = `{shr_pg_row, cpu_addr[13:7]}` with `shr_ras_n` low. The column phase drives `ma` = `{shr_pg_col, cpu_addr[6:0]}`, and `shr_cas_n` goes low one clock later.
- R5: A bank's CAS is low only while its RAS is low, and CAS falls no earlier than two clocks after RAS fell.
- R6: Only the selected bank's strobes are driven. During a shared-bank cycle `fast_ras_n` and `fast_cas_n` stay high, and during a fast-bank cycle `shr_ras_n` and `shr_cas_n` stay high.
- R7: `we_n` is low on the clock after an edge at which a cycle is active (or starting), `wr_n` is low and `rd_n` is high. Otherwise it is high, and it is high when `rd_n` and `wr_n` are both low.
- R8: A clock edge with `mreq_n` high makes all strobes and `we_n` high after that edge, including when this happens before CAS has been issued.
- R9: A request with `cpu_addr[15:14]` = 0 issues no strobe, however long `mreq_n` stays low.
- R10: Address and page bits are captured at the start edge. Changes to `cpu_addr`, the page bits or `bank_shared` during a cycle do not alter `ma` or the bank strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bank_shared | input | 1 | 1 selects the shared bank, 0 the fast bank |
| fast_pg_row | input | 1 | Fast-bank page bit placed on the row MSB |
| fast_pg_col | input | 1 | Fast-bank page bit placed on the column MSB |
| shr_pg_row | input | 1 | Shared-bank page bit placed on the row MSB |
| shr_pg_col | input | 1 | Shared-bank page bit placed on the column MSB |
| ma | output | 8 | Multiplexed DRAM address |
| fast_ras_n | output | 1 | Fast-bank row strobe, active low |
| fast_cas_n | output | 1 | Fast-bank column strobe, active low |
| shr_ras_n | output | 1 | Shared-bank row strobe, active low |
| shr_cas_n | output | 1 | Shared-bank column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |

## Verification
The assertions take the bus to be synchronous to `clk`: `mreq_n`, `rd_n`, `wr_n` and the address are treated as clean levels sampled at the rising edge. A request is taken to stay low until the bus is done with it and then to return high for at least one edge before the next request. The bench changes every input only on the falling clock edge. It always raises `mreq_n` between requests and holds it low through each complete cycle it checks, except where it ends a request early on purpose. It changes the address, page bits or bank select during a cycle only to show that they are ignored.

// File: rtl/dram_mux_pkg.sv
// Shared types for the dual-bank DRAM address multiplexer.
// Assumes two banks: index 0 is the fast bank, index 1 the shared bank.
package dram_mux_pkg;

    // Phase of one DRAM access.
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_ROW    = 2'd1,
        CYC_COLSET = 2'd2,
        CYC_STROBE = 2'd3
    } cyc_state_e;

    // Bank chosen for an access.
    typedef enum logic {
        BANK_FAST   = 1'b0,
        BANK_SHARED = 1'b1
    } bank_e;

endpackage

// File: rtl/dram_cycle_fsm.sv
// Access sequencer: walks idle -> row -> column setup -> column strobe.
// Assumes mreq_n is synchronous to clk. A cycle starts only for a RAM address,
// and any edge that sees mreq_n high returns the sequencer to idle.
module dram_cycle_fsm
    import dram_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mreq_n,
    input  logic       in_ram,
    output cyc_state_e state_q,
    output cyc_state_e state_nxt,
    output logic       capture
);

    // Next-state decode for the access sequence.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            CYC_IDLE:   state_nxt = (!mreq_n && in_ram) ? CYC_ROW : CYC_IDLE;
            CYC_ROW:    state_nxt = mreq_n ? CYC_IDLE : CYC_COLSET;
            CYC_COLSET: state_nxt = mreq_n ? CYC_IDLE : CYC_STROBE;
            CYC_STROBE: state_nxt = mreq_n ? CYC_IDLE : CYC_STROBE;
            default:    state_nxt = CYC_IDLE;
        endcase
    end

    // Request capture happens on the edge that leaves idle.
    assign capture = (state_q == CYC_IDLE) && (state_nxt == CYC_ROW);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_nxt;
    end

endmodule

// File: rtl/dram_addr_sel.sv
// Row/column address former. Purely combinational.
// Assumes the CPU address slice is 2*HALF bits wide. The fast bank rows on the low
// half and columns on the high half; the shared bank does the reverse. A page
// bit is placed above each half.
module dram_addr_sel
    import dram_mux_pkg::*;
#(
    parameter int HALF = 7
) (
    input  logic [2*HALF-1:0] addr,
    input  bank_e             bank,
    input  logic              col_phase,
    input  logic              pg_row_fast,
    input  logic              pg_col_fast,
    input  logic              pg_row_shr,
    input  logic              pg_col_shr,
    output logic [HALF:0]     ma
);

    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;

    assign lo_half = addr[HALF-1:0];
    assign hi_half = addr[2*HALF-1:HALF];

    // Choose the half and the page bit for the current bank and phase.
    always_comb begin
        unique case ({bank, col_phase})
            {BANK_FAST, 1'b0}:   ma = {pg_row_fast, lo_half};
            {BANK_FAST, 1'b1}:   ma = {pg_col_fast, hi_half};
            {BANK_SHARED, 1'b0}: ma = {pg_row_shr, hi_half};
            default:             ma = {pg_col_shr, lo_half};
        endcase
    end

endmodule

// File: rtl/dram_strobe_gen.sv
// Registered strobe and address outputs for NBANK banks.
// Assumes the next sequencer state and the bank index are valid at each edge.
// Every output is a flop, so the strobes do not glitch.
module dram_strobe_gen
    import dram_mux_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int MW    = 8,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cyc_state_e       state_nxt,
    input  logic [BW-1:0]    bank_idx,
    input  logic [MW-1:0]    ma_nxt,
    input  logic             wr_req,
    output logic [NBANK-1:0] ras_n,
    output logic [NBANK-1:0] cas_n,
    output logic             we_n,
    output logic [MW-1:0]    ma
);

    logic active_nxt;
    assign active_nxt = (state_nxt != CYC_IDLE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic ras_r;
        logic cas_r;

        // Per-bank strobe flops: only the addressed bank is driven.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ras_r <= 1'b1;
                cas_r <= 1'b1;
            end else begin
                ras_r <= !(active_nxt && bank_idx == BW'(b));
                cas_r <= !(state_nxt == CYC_STROBE && bank_idx == BW'(b));
            end
        end

        assign ras_n[b] = ras_r;
        assign cas_n[b] = cas_r;
    end

    // Write enable follows the bus write strobe while an access is active.
    always_ff @(posedge clk) begin
        if (!rst_n) we_n <= 1'b1;
        else        we_n <= !(active_nxt && wr_req);
    end

    // Multiplexed address flop; held while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          ma <= '0;
        else if (active_nxt) ma <= ma_nxt;
    end

endmodule

// File: rtl/dram_addr_mux.sv
// Dual-bank DRAM address multiplexer top.
// Captures a RAM request, then sequences row address + RAS, column address,
// then CAS for the selected bank. Assumes a synchronous bus in which the request
// returns high between accesses. The lowest quarter of the address space is
// treated as non-RAM.
module dram_addr_mux
    import dram_mux_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*MW-1:0] cpu_addr,
    input  logic            mreq_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            bank_shared,
    input  logic            fast_pg_row,
    input  logic            fast_pg_col,
    input  logic            shr_pg_row,
    input  logic            shr_pg_col,
    output logic [MW-1:0]   ma,
    output logic            fast_ras_n,
    output logic            fast_cas_n,
    output logic            shr_ras_n,
    output logic            shr_cas_n,
    output logic            we_n
);

    localparam int AW    = 2 * MW;
    localparam int HALF  = MW - 1;
    localparam int NBANK = 2;

    cyc_state_e      state_q;
    cyc_state_e      state_nxt;
    logic            capture;
    logic            in_ram;

    logic [AW-1:0]   addr_q;
    bank_e           bank_q;
    logic [3:0]      pg_q;

    logic [AW-1:0]   addr_src;
    bank_e           bank_src;
    logic [3:0]      pg_src;
    logic            col_phase;
    logic [MW-1:0]   ma_nxt;
    logic            wr_req;
    logic [NBANK-1:0] ras_v;
    logic [NBANK-1:0] cas_v;

    // Any address above the lowest quarter lies in RAM.
    assign in_ram = |cpu_addr[AW-1:AW-2];

    dram_cycle_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mreq_n    (mreq_n),
        .in_ram    (in_ram),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .capture   (capture)
    );

    // Request latch: address, bank and page bits frozen for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            bank_q <= BANK_FAST;
            pg_q   <= '0;
        end else if (capture) begin
            addr_q <= cpu_addr;
            bank_q <= bank_e'(bank_shared);
            pg_q   <= {shr_pg_col, shr_pg_row, fast_pg_col, fast_pg_row};
        end
    end

    // On the capture edge use live inputs; afterwards use the latched copy.
    assign addr_src  = capture ? cpu_addr : addr_q;
    assign bank_src  = capture ? bank_e'(bank_shared) : bank_q;
    assign pg_src    = capture ? {shr_pg_col, shr_pg_row, fast_pg_col, fast_pg_row} : pg_q;
    assign col_phase = (state_nxt == CYC_COLSET) || (state_nxt == CYC_STROBE);
    assign wr_req    = !wr_n && rd_n;

    dram_addr_sel #(.HALF(HALF)) i_sel (
        .addr        (addr_src[2*HALF-1:0]),
        .bank        (bank_src),
        .col_phase   (col_phase),
        .pg_row_fast (pg_src[0]),
        .pg_col_fast (pg_src[1]),
        .pg_row_shr  (pg_src[2]),
        .pg_col_shr  (pg_src[3]),
        .ma          (ma_nxt)
    );

    dram_strobe_gen #(.NBANK(NBANK), .MW(MW)) i_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .bank_idx  (bank_src),
        .ma_nxt    (ma_nxt),
        .wr_req    (wr_req),
        .ras_n     (ras_v),
        .cas_n     (cas_v),
        .we_n      (we_n),
        .ma        (ma)
    );

    assign fast_ras_n = ras_v[0];
    assign fast_cas_n = cas_v[0];
    assign shr_ras_n  = ras_v[1];
    assign shr_cas_n  = cas_v[1];

endmodule

// File: rtl/dram_addr_mux_chk.sv
// Protocol checker for dram_addr_mux, attached by bind.
// Assumes synchronous bus inputs sampled on the rising clock edge.
module dram_addr_mux_chk #(
    parameter int MW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*MW-1:0] cpu_addr,
    input logic            mreq_n,
    input logic [MW-1:0]   ma,
    input logic            fast_ras_n,
    input logic            fast_cas_n,
    input logic            shr_ras_n,
    input logic            shr_cas_n,
    input logic            we_n
);

    // R5: CAS only under its own RAS.
    a_r5_fast_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_cas_n |-> !fast_ras_n);
    a_r5_shr_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !shr_cas_n |-> !shr_ras_n);

    // R5: RAS has been low for at least two clocks when CAS falls.
    a_r5_fast_ras_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_cas_n) |-> (!$past(fast_ras_n, 1) && !$past(fast_ras_n, 2)));
    a_r5_shr_ras_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shr_cas_n) |-> (!$past(shr_ras_n, 1) && !$past(shr_ras_n, 2)));

    // R6: never two banks strobed together.
    a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~fast_ras_n, ~shr_ras_n}) <= 1);

    // R3: column address stays put while CAS is held.
    a_r3_ma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_cas_n || !shr_cas_n) && !mreq_n |=> (fast_cas_n && shr_cas_n) || $stable(ma));

    // R8: request released means everything released next clock.
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |=> (fast_ras_n && fast_cas_n && shr_ras_n && shr_cas_n && we_n));

    // R9: no access starts for a non-RAM address.
    a_r9_rom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_ras_n && shr_ras_n && cpu_addr[2*MW-1:2*MW-2] == 2'b00)
        |=> (fast_ras_n && shr_ras_n));

    // R7: write enable only inside an access.
    a_r7_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!fast_ras_n || !shr_ras_n));

endmodule

bind dram_addr_mux dram_addr_mux_chk #(.MW(MW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .mreq_n     (mreq_n),
    .ma         (ma),
    .fast_ras_n (fast_ras_n),
    .fast_cas_n (fast_cas_n),
    .shr_ras_n  (shr_ras_n),
    .shr_cas_n  (shr_cas_n),
    .we_n       (we_n)
);

// File: tb/test_dram_addr_mux.sv
// Directed bench for dram_addr_mux: one task per scenario.
module test_dram_addr_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mreq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        bank_shared = 1'b0;
    logic        fast_pg_row = 1'b0;
    logic        fast_pg_col = 1'b0;
    logic        shr_pg_row = 1'b0;
    logic        shr_pg_col = 1'b0;
    logic [7:0]  ma;
    logic        fast_ras_n, fast_cas_n, shr_ras_n, shr_cas_n, we_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dram_addr_mux i_dram_addr_mux (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
        .rd_n(rd_n), .wr_n(wr_n), .bank_shared(bank_shared),
        .fast_pg_row(fast_pg_row), .fast_pg_col(fast_pg_col),
        .shr_pg_row(shr_pg_row), .shr_pg_col(shr_pg_col),
        .ma(ma), .fast_ras_n(fast_ras_n), .fast_cas_n(fast_cas_n),
        .shr_ras_n(shr_ras_n), .shr_cas_n(shr_cas_n), .we_n(we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {fast_ras_n, fast_cas_n, shr_ras_n, shr_cas_n};
    endfunction

    function automatic logic [7:0] exp_row(bit sh, logic [15:0] a, bit fr, bit sr);
        return sh ? {sr, a[13:7]} : {fr, a[6:0]};
    endfunction

    function automatic logic [7:0] exp_col(bit sh, logic [15:0] a, bit fc, bit sc);
        return sh ? {sc, a[6:0]} : {fc, a[13:7]};
    endfunction

    // One full access; optional scramble of inputs after the start edge.
    task automatic run_cycle(input bit sh, input logic [15:0] a, input logic [3:0] pg,
                             input bit rd, input bit wr, input bit scramble);
        logic [3:0] s_ras;
        logic [3:0] s_cas;
        bit exp_we;
        s_ras  = sh ? 4'b1101 : 4'b0111;
        s_cas  = sh ? 4'b1100 : 4'b0011;
        exp_we = !(wr && !rd);
        @(negedge clk);
        cpu_addr = a; bank_shared = sh; mreq_n = 1'b0;
        {shr_pg_col, shr_pg_row, fast_pg_col, fast_pg_row} = pg;
        rd_n = !rd; wr_n = !wr;
        @(negedge clk);
        chk(sh ? "R4 row addr" : "R2 row addr", ma, exp_row(sh, a, pg[0], pg[2]));
        chk("R6 row strobes", strobes(), s_ras);
        chk("R7 we", we_n, exp_we);
        if (scramble) begin
            cpu_addr = ~a; bank_shared = !sh;
            {shr_pg_col, shr_pg_row, fast_pg_col, fast_pg_row} = ~pg;
        end
        @(negedge clk);
        chk(sh ? "R4 col addr" : "R3 col addr", ma, exp_col(sh, a, pg[1], pg[3]));
        chk("R5 cas still high", strobes(), s_ras);
        @(negedge clk);
        chk(sh ? "R4 cas low" : "R3 cas low", strobes(), s_cas);
        chk("R3 col held", ma, exp_col(sh, a, pg[1], pg[3]));
        if (scramble) chk("R10 inputs ignored", {ma, strobes()}, {exp_col(sh, a, pg[1], pg[3]), s_cas});
        mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R8 release", {strobes(), we_n}, 5'b11111);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {strobes(), we_n}, 5'b11111);
        chk("R1 reset ma", ma, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_fast();
        run_cycle(1'b0, 16'h8000 | 16'h1A5B, 4'b0101, 1'b1, 1'b0, 1'b0);
        run_cycle(1'b0, 16'h7FFF, 4'b0011, 1'b0, 1'b1, 1'b0);   // R7 write
        run_cycle(1'b0, 16'h4000, 4'b0000, 1'b1, 1'b0, 1'b0);   // lowest RAM address
    endtask

    task automatic t_shared();
        run_cycle(1'b1, 16'hC3C3, 4'b1010, 1'b1, 1'b0, 1'b0);
        run_cycle(1'b1, 16'hFFFF, 4'b1100, 1'b0, 1'b1, 1'b0);
        run_cycle(1'b1, 16'h5555, 4'b0110, 1'b1, 1'b1, 1'b0);   // R7 both low -> read
    endtask

    task automatic t_hold();
        run_cycle(1'b0, 16'h9F0E, 4'b1001, 1'b1, 1'b0, 1'b1);   // R10
        run_cycle(1'b1, 16'hA001, 4'b0110, 1'b0, 1'b1, 1'b1);   // R10
    endtask

    task automatic t_rom();
        @(negedge clk);
        cpu_addr = 16'h3FFF; mreq_n = 1'b0; rd_n = 1'b0; bank_shared = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 rom no strobe", {strobes(), we_n}, 5'b11111);
        end
        mreq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_abort();
        @(negedge clk);
        cpu_addr = 16'hB234; bank_shared = 1'b1; mreq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        chk("R4 abort row", strobes(), 4'b1101);
        mreq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        chk("R8 abort release", {strobes(), we_n}, 5'b11111);
        @(negedge clk);
        chk("R8 stays idle", strobes(), 4'b1111);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fast();
        t_shared();
        t_hold();
        t_rom();
        t_abort();
        run_cycle(1'b0, 16'hE07F, 4'b1111, 1'b1, 1'b0, 1'b0);   // after abort
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule